// File: doc/BRIEF.md
# LCD Dot Clock Generator

This block derives two timing strobes for an LCD panel from one of two selectable source strobes. The dot strobe is the chosen source slowed down by a programmable ratio from 1 to 32. The panel shift strobe comes from a second stage that depends on the panel type. For thin-film panels it is the dot strobe itself. For passive-matrix panels it is the dot strobe divided again by the width of the panel's output data bus.

All timing lives in one reference clock domain. Each source arrives as a one-cycle enable strobe, and both outputs are one-cycle enable pulses, so no real clock is gated or multiplexed. Software sets the source and the ratio through a 16-bit control word. That word also reads back fixed values in its reserved positions.

Top module: `lcd_dotclk_gen`

## Requirements
- R1: After reset, `rd_data` reads 16'h0101. The source field is 00, the division field is 1, bit 8 is 1, and `dot_en`, `shift_en` and `ratio_err` are low.
- R2: `rd_data` always equals {2'b00, src[1:0], 3'b000, 1'b1, 2'b00, div[5:0]}. Here src holds `wr_data[13:12]` and div holds `wr_data[5:0]` from the most recent write. Writes to any other bit have no effect on the read value.
- R3: While the source field holds 00 or 11, `dot_en` and `shift_en` stay low whatever the strobe inputs do.
- R4: With source field 01, only `periph_stb` is counted. With source field 10, only `ext_stb` is counted.
- R5: With a division value N from 1 to 32, `dot_en` is high in the same cycle as every N-th counted strobe after the last write, and low at all other times.
- R6: A division value of 0 or above 32 divides by 1 and holds `ratio_err` high. For a value from 1 to 32, `ratio_err` is low.
- R7: With `panel_stn` = 0 (thin-film panel), `shift_en` equals `dot_en` in every cycle.
- R8: With `panel_stn` = 1 (passive panel), `shift_en` is high together with every W-th `dot_en`. W is 1 for `bus_width_sel` 00, 4 for 01, and 8 for 10 or 11.
- R9: A cycle with `wr_en` high produces no `dot_en` or `shift_en`. Counting for both stages restarts from zero after that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 16 | Control word write value |
| rd_data | output | 16 | Control word read value |
| periph_stb | input | 1 | Peripheral source enable strobe |
| ext_stb | input | 1 | External source enable strobe |
| panel_stn | input | 1 | 0: thin-film panel, 1: passive panel |
| bus_width_sel | input | 2 | Panel output bus width code |
| dot_en | output | 1 | Dot clock enable pulse |
| shift_en | output | 1 | Panel shift clock enable pulse |
| ratio_err | output | 1 | Division value out of range |

## Verification
The hardest state to reach is a passive panel with an 8-bit bus and a large division ratio. There, one shift pulse needs 8 × 32 counted strobes with no write in between. A write arriving partway through the count must also be seen to clear both counters. The stimulus reaches this with long runs of dense `ext_stb` strobes under ratio 32, then rewrites the control word in the middle of a count. A cycle-accurate model in the bench tracks both counters and flags the first pulse that comes early or late.

// File: rtl/lcd_clk_pkg.sv
package lcd_clk_pkg;

   typedef enum logic [1:0] {
      SRC_OFF    = 2'b00,
      SRC_PERIPH = 2'b01,
      SRC_EXT    = 2'b10,
      SRC_BAD    = 2'b11
   } lcd_src_e;

   typedef enum logic [1:0] {
      BW_NARROW = 2'b00,
      BW_MID    = 2'b01,
      BW_WIDE   = 2'b10,
      BW_WIDE2  = 2'b11
   } lcd_bw_e;

endpackage

// File: rtl/lcd_clk_regs.sv
module lcd_clk_regs #(
   parameter int DATA_W   = 16,
   parameter int DIV_W    = 6,
   parameter int SRC_LSB  = 12,
   parameter int ONE_BIT  = 8,
   parameter int DIV_INIT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output lcd_clk_pkg::lcd_src_e src_o,
   output logic [DIV_W-1:0]  div_o,
   output logic [DATA_W-1:0] rd_data
);
   import lcd_clk_pkg::*;

   localparam logic [DATA_W-1:0] USED_MASK =
      (DATA_W'(3) << SRC_LSB) | DATA_W'((1 << DIV_W) - 1);

   generate
      if (SRC_LSB + 2 > DATA_W) begin : g_bad_src
         $error("source field does not fit the control word");
      end
      if (DIV_W >= SRC_LSB || ONE_BIT < DIV_W || ONE_BIT >= SRC_LSB) begin : g_bad_layout
         $error("control word fields overlap");
      end
   endgenerate

   lcd_src_e         src_q;
   logic [DIV_W-1:0] div_q;
   logic             unused_wr_bits;

   assign unused_wr_bits = ^(wr_data & ~USED_MASK);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q <= SRC_OFF;
         div_q <= DIV_W'(DIV_INIT);
      end else if (wr_en) begin
         src_q <= lcd_src_e'(wr_data[SRC_LSB +: 2]);
         div_q <= wr_data[DIV_W-1:0];
      end
   end

   always_comb begin
      rd_data               = '0;
      rd_data[ONE_BIT]      = 1'b1;
      rd_data[SRC_LSB +: 2] = src_q;
      rd_data[DIV_W-1:0]    = div_q;
   end

   assign src_o = src_q;
   assign div_o = div_q;

endmodule

// File: rtl/lcd_clk_ratio.sv
module lcd_clk_ratio #(
   parameter int DIV_W   = 6,
   parameter int MAX_DIV = 32,
   parameter int CNT_W   = 5
) (
   input  logic [DIV_W-1:0] div_i,
   output logic [CNT_W-1:0] term_o,
   output logic             err_o
);
   generate
      if (MAX_DIV >= (1 << DIV_W)) begin : g_bad_max
         $error("largest ratio exceeds the division field");
      end
   endgenerate

   logic legal;

   assign legal  = (div_i != '0) && (int'(div_i) <= MAX_DIV);
   assign err_o  = ~legal;
   assign term_o = legal ? CNT_W'(div_i - DIV_W'(1)) : '0;

endmodule

// File: rtl/lcd_clk_divider.sv
module lcd_clk_divider #(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             tick,
   input  logic [CNT_W-1:0] term,
   output logic             pulse
);
   logic [CNT_W-1:0] cnt_q;
   logic             wrap;

   assign wrap  = cnt_q >= term;
   assign pulse = tick & ~clr & wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_q <= '0;
      else if (clr)  cnt_q <= '0;
      else if (tick) cnt_q <= wrap ? '0 : cnt_q + CNT_W'(1);
   end

endmodule

// File: rtl/lcd_dotclk_gen.sv
module lcd_dotclk_gen #(
   parameter int DATA_W  = 16,
   parameter int DIV_W   = 6,
   parameter int MAX_DIV = 32,
   parameter int SRC_LSB = 12,
   parameter int ONE_BIT = 8,
   parameter int BW_N    = 1,
   parameter int BW_M    = 4,
   parameter int BW_W    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   input  logic              periph_stb,
   input  logic              ext_stb,
   input  logic              panel_stn,
   input  logic [1:0]        bus_width_sel,
   output logic              dot_en,
   output logic              shift_en,
   output logic              ratio_err
);
   import lcd_clk_pkg::*;

   localparam int CNT_W  = (MAX_DIV > 1) ? $clog2(MAX_DIV) : 1;
   localparam int CNT2_W = (BW_W > 1) ? $clog2(BW_W) : 1;

   generate
      if (BW_N < 1 || BW_M < BW_N || BW_W < BW_M) begin : g_bad_bw
         $error("bus widths must be ascending and at least one");
      end
   endgenerate

   lcd_src_e         src;
   logic [DIV_W-1:0] div;
   logic [CNT_W-1:0] term;
   logic             src_stb;

   lcd_clk_regs #(
      .DATA_W(DATA_W), .DIV_W(DIV_W), .SRC_LSB(SRC_LSB),
      .ONE_BIT(ONE_BIT), .DIV_INIT(1)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .src_o(src), .div_o(div), .rd_data(rd_data)
   );

   lcd_clk_ratio #(.DIV_W(DIV_W), .MAX_DIV(MAX_DIV), .CNT_W(CNT_W)) u_ratio (
      .div_i(div), .term_o(term), .err_o(ratio_err)
   );

   always_comb begin
      unique case (src)
         SRC_PERIPH: src_stb = periph_stb;
         SRC_EXT:    src_stb = ext_stb;
         default:    src_stb = 1'b0;
      endcase
   end

   lcd_clk_divider #(.CNT_W(CNT_W)) u_dot_div (
      .clk(clk), .rst_n(rst_n), .clr(wr_en), .tick(src_stb),
      .term(term), .pulse(dot_en)
   );

   generate
      if (BW_W == 1) begin : g_no_shift_div
         logic unused_shift_in;
         assign unused_shift_in = ^{panel_stn, bus_width_sel};
         assign shift_en = dot_en;
      end else begin : g_shift_div
         logic [CNT2_W-1:0] term2;
         logic              pass_div;

         always_comb begin
            unique case (lcd_bw_e'(bus_width_sel))
               BW_NARROW: term2 = CNT2_W'(BW_N - 1);
               BW_MID:    term2 = CNT2_W'(BW_M - 1);
               default:   term2 = CNT2_W'(BW_W - 1);
            endcase
         end

         lcd_clk_divider #(.CNT_W(CNT2_W)) u_shift_div (
            .clk(clk), .rst_n(rst_n), .clr(wr_en), .tick(dot_en),
            .term(term2), .pulse(pass_div)
         );

         assign shift_en = panel_stn ? pass_div : dot_en;
      end
   endgenerate

endmodule

// File: rtl/lcd_dotclk_chk.sv
module lcd_dotclk_chk #(
   parameter int DATA_W  = 16,
   parameter int DIV_W   = 6,
   parameter int MAX_DIV = 32,
   parameter int SRC_LSB = 12,
   parameter int ONE_BIT = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [DATA_W-1:0] rd_data,
   input logic              periph_stb,
   input logic              ext_stb,
   input logic              panel_stn,
   input logic              dot_en,
   input logic              shift_en,
   input logic              ratio_err
);
   logic [1:0]       c_src;
   logic [DIV_W-1:0] c_div;
   logic             c_bad_div;
   logic             c_counted;

   assign c_src     = rd_data[SRC_LSB +: 2];
   assign c_div     = rd_data[DIV_W-1:0];
   assign c_bad_div = (c_div == '0) || (int'(c_div) > MAX_DIV);
   assign c_counted = (c_src == 2'b01 && periph_stb) || (c_src == 2'b10 && ext_stb);

   assert_fixed_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[ONE_BIT] && rd_data[SRC_LSB-1:ONE_BIT+1] == '0 && rd_data[ONE_BIT-1:DIV_W] == '0);

   assert_prohibited_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (c_src == 2'b00 || c_src == 2'b11) |-> (!dot_en && !shift_en));

   assert_dot_needs_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
      dot_en |-> c_counted);

   assert_unit_ratio_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((c_div == DIV_W'(1) || c_bad_div) && c_counted && !wr_en) |-> dot_en);

   assert_err_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ratio_err == c_bad_div);

   assert_tft_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !panel_stn |-> (shift_en == dot_en));

   assert_shift_subset_R8: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en |-> dot_en);

   assert_write_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (!dot_en && !shift_en));

endmodule

bind lcd_dotclk_gen lcd_dotclk_chk #(
   .DATA_W(DATA_W), .DIV_W(DIV_W), .MAX_DIV(MAX_DIV),
   .SRC_LSB(SRC_LSB), .ONE_BIT(ONE_BIT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_data(rd_data),
   .periph_stb(periph_stb), .ext_stb(ext_stb), .panel_stn(panel_stn),
   .dot_en(dot_en), .shift_en(shift_en), .ratio_err(ratio_err)
);

// File: tb/lcd_dotclk_gen_tb_top.sv
module lcd_dotclk_gen_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic [15:0] rd_data;
   logic        periph_stb = 1'b0;
   logic        ext_stb = 1'b0;
   logic        panel_stn = 1'b0;
   logic [1:0]  bus_width_sel = 2'b00;
   logic        dot_en, shift_en, ratio_err;

   int n_cmp = 0;
   int n_bad = 0;
   int m_src, m_div, m_cnt, m_cnt2;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   lcd_dotclk_gen dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .periph_stb(periph_stb), .ext_stb(ext_stb),
      .panel_stn(panel_stn), .bus_width_sel(bus_width_sel),
      .dot_en(dot_en), .shift_en(shift_en), .ratio_err(ratio_err)
   );

   task automatic cmp(string tag, string what, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic step(string tag, bit w, logic [15:0] wd, bit p, bit e, bit stn, logic [1:0] bw);
      int ratio, width, stb;
      bit x_dot, x_shift, x_err;
      @(negedge clk);
      wr_en = w; wr_data = wd; periph_stb = p; ext_stb = e;
      panel_stn = stn; bus_width_sel = bw;
      #1;
      x_err = !(m_div >= 1 && m_div <= 32);
      ratio = x_err ? 1 : m_div;
      width = (bw == 2'b00) ? 1 : (bw == 2'b01) ? 4 : 8;
      stb   = (m_src == 1) ? int'(p) : (m_src == 2) ? int'(e) : 0;
      x_dot = !w && stb != 0 && (m_cnt >= ratio - 1);
      x_shift = stn ? (x_dot && m_cnt2 >= width - 1) : x_dot;
      cmp(tag, "dot_en", int'(dot_en), int'(x_dot));
      cmp(tag, "shift_en", int'(shift_en), int'(x_shift));
      cmp(tag, "ratio_err", int'(ratio_err), int'(x_err));
      cmp(tag, "rd_data", int'(rd_data), 32'h0100 | (m_src << 12) | m_div);
      if (w) begin
         m_src = int'(wd[13:12]); m_div = int'(wd[5:0]);
         m_cnt = 0; m_cnt2 = 0;
      end else begin
         if (stb != 0) m_cnt = (m_cnt >= ratio - 1) ? 0 : m_cnt + 1;
         if (x_dot) m_cnt2 = (m_cnt2 >= width - 1) ? 0 : m_cnt2 + 1;
      end
   endtask

   task automatic run(string tag, int n, int p_pct, int e_pct, bit stn, logic [1:0] bw);
      for (int i = 0; i < n; i++)
         step(tag, 1'b0, 16'h0, ($urandom % 100) < p_pct, ($urandom % 100) < e_pct, stn, bw);
   endtask

   task automatic wr(string tag, logic [15:0] wd, bit stn, logic [1:0] bw);
      step(tag, 1'b1, wd, 1'b1, 1'b1, stn, bw);
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      m_src = 0; m_div = 1; m_cnt = 0; m_cnt2 = 0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      // R1: reset values
      cmp("R1", "rd_data reset", int'(rd_data), 32'h0101);
      cmp("R1", "ratio_err reset", int'(ratio_err), 0);
      // R3: prohibited codes 00 and 11
      run("R3", 30, 80, 80, 1'b0, 2'b00);
      wr("R3", 16'h3003, 1'b0, 2'b00);
      run("R3", 30, 80, 80, 1'b1, 2'b00);
      // R2: reserved bits ignore writes
      wr("R2", 16'hFFFF, 1'b0, 2'b00);
      run("R2", 5, 50, 50, 1'b0, 2'b00);
      wr("R2", 16'hCEC5, 1'b0, 2'b00);
      run("R2", 5, 50, 50, 1'b0, 2'b00);
      // R4/R5: peripheral source, ratio 5, external strobes ignored
      wr("R4", 16'h1005, 1'b0, 2'b00);
      run("R4", 80, 60, 90, 1'b0, 2'b00);
      // R4/R5: external source, ratio 32, peripheral strobes ignored
      wr("R5", 16'h2020, 1'b0, 2'b00);
      run("R5", 150, 90, 100, 1'b0, 2'b00);
      wr("R5", 16'h2001, 1'b0, 2'b00);
      run("R5", 30, 50, 50, 1'b0, 2'b00);
      wr("R5", 16'h1003, 1'b0, 2'b00);
      run("R5", 40, 100, 0, 1'b0, 2'b00);
      // R6: out-of-range ratios
      wr("R6", 16'h1000, 1'b0, 2'b00);
      run("R6", 30, 50, 50, 1'b0, 2'b00);
      wr("R6", 16'h2028, 1'b0, 2'b00);
      run("R6", 30, 50, 50, 1'b0, 2'b00);
      wr("R6", 16'h2021, 1'b0, 2'b00);
      run("R6", 20, 50, 50, 1'b0, 2'b00);
      // R7: thin-film panel
      wr("R7", 16'h1002, 1'b0, 2'b10);
      run("R7", 60, 70, 70, 1'b0, 2'b10);
      // R8: passive panel, each width code
      wr("R8", 16'h1002, 1'b1, 2'b00);
      run("R8", 60, 70, 30, 1'b1, 2'b00);
      wr("R8", 16'h2003, 1'b1, 2'b01);
      run("R8", 150, 30, 90, 1'b1, 2'b01);
      wr("R8", 16'h2001, 1'b1, 2'b10);
      run("R8", 120, 0, 80, 1'b1, 2'b10);
      wr("R8", 16'h2004, 1'b1, 2'b11);
      run("R8", 200, 0, 100, 1'b1, 2'b11);
      // R8 long: ratio 32 with 8-bit bus
      wr("R8", 16'h2020, 1'b1, 2'b10);
      run("R8", 600, 0, 100, 1'b1, 2'b10);
      // R9: rewrite mid-count restarts both stages
      run("R9", 90, 0, 100, 1'b1, 2'b10);
      wr("R9", 16'h2020, 1'b1, 2'b10);
      run("R9", 300, 0, 100, 1'b1, 2'b10);
      wr("R9", 16'h1004, 1'b1, 2'b01);
      run("R9", 10, 100, 0, 1'b1, 2'b01);
      wr("R9", 16'h1004, 1'b1, 2'b01);
      run("R9", 60, 100, 0, 1'b1, 2'b01);
      finished = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog expired actual=running expected=done");
         summary();
         $finish;
      end
   end

endmodule